// File: doc/BRIEF.md
# Signed Residue Scaler by 2^n

This block divides a signed integer by 2^n while the integer stays in residue form over the three moduli 2^n−1, 2^n and 2^n+1. The product of the moduli, M = 2^n·(2^(2n)−1), is the dynamic range. Encodings in the upper half, X in [M/2, M), stand for the negative value X − M. The quotient is the floor of the signed value divided by 2^n, which rounds toward negative infinity, and it is returned as three residues in the same moduli.

The datapath first scales the input as if it were unsigned. It takes the residue differences in the outer channels, then rebuilds the unsigned quotient Y in binary from those two channels by a rotate and two shifted adds. The middle residue is the low n bits of Y. The upper half of the range is recognised from the top bit of Y plus one bit of the input's middle residue, so no separate comparator over the whole range is needed. Subtracting M/2^n = 2^(2n)−1 from a negative quotient leaves both outer residues unchanged and adds one to the middle residue modulo 2^n. That increment is the whole sign correction.

The block is a two-stage pipeline with a valid flag. It is intended for residue-arithmetic datapaths that must bring a value back into range between operations. The width n is a parameter, and the block is meant for n from 5 to 8. It also works for n = 3 and 4, which keeps exhaustive checking cheap.

Top module: `rns_signed_scaler`

## Requirements
- R1: When out_valid is high, out_r_lo equals the floor-divided signed quotient reduced into [0, 2^n−2].
- R2: When out_valid is high, out_r_mid equals the floor-divided signed quotient reduced into [0, 2^n−1].
- R3: When out_valid is high, out_r_hi equals the floor-divided signed quotient reduced into [0, 2^n].
- R4: The encoding X = M/2 − 1 is taken as positive, and X = M/2 is taken as the negative value −M/2. For example, M/2 gives the quotient −2^(2n−1), and M − 1 (that is, −1) gives the quotient −1.
- R5: While rst is high at a rising clock edge, out_valid and all three output residues are 0 after that edge.
- R6: out_valid at the end of a cycle equals in_valid as sampled two rising edges earlier. The latency is exactly two cycles.
- R7: While out_valid is low, the three output residues hold their last value whatever the inputs do.
- R8: Input residues are canonical: in_r_lo is in [0, 2^n−2], in_r_mid is in [0, 2^n−1] and in_r_hi is in [0, 2^n]. Outputs are canonical in the same ranges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input residues are valid this cycle |
| in_r_lo | input | N | Residue modulo 2^n−1 |
| in_r_mid | input | N | Residue modulo 2^n |
| in_r_hi | input | N+1 | Residue modulo 2^n+1 |
| out_valid | output | 1 | Output residues are valid |
| out_r_lo | output | N | Scaled residue modulo 2^n−1 |
| out_r_mid | output | N | Scaled residue modulo 2^n |
| out_r_hi | output | N+1 | Scaled residue modulo 2^n+1 |

## Verification
A fault appears at the outputs two cycles after the input that exposes it, because the pipeline holds no state longer than that. A fault in an outer-channel difference corrupts its own output residue. Through the binary rebuild, it also garbles the middle residue. A fault in the rebuild or in the sign decision shows only in out_r_mid, usually as an off-by-one value. The sign fault appears only for inputs close to the half-range boundary. The sweeps therefore cover every encoding for n = 3 and 4, so that each boundary neighbour is exercised.

// File: rtl/rns_scale_pkg.sv
package rns_scale_pkg;

    localparam int unsigned N_LOW  = 3;
    localparam int unsigned N_HIGH = 8;

    typedef enum logic {
        SGN_NONNEG = 1'b0,
        SGN_NEG    = 1'b1
    } sgn_e;

    function automatic bit n_supported(int unsigned n);
        return (n >= N_LOW) && (n <= N_HIGH);
    endfunction

endpackage

// File: rtl/rns_chan_diff.sv
module rns_chan_diff #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] x_lo,
    input  logic [N-1:0] x_mid,
    input  logic [N:0]   x_hi,
    output logic [N-1:0] y_lo,
    output logic [N:0]   y_hi
);
    localparam logic [N:0]   MOD_LO = {1'b0, {N{1'b1}}};
    localparam logic [N+1:0] MOD_HI = {2'b01, {(N-1){1'b0}}, 1'b1};

    logic [N-1:0] mid_red;
    logic [N:0]   d_lo, d_lo_w;
    logic [N+1:0] d_hi, d_hi_w;

    // y_lo = (x_lo - x_mid) mod 2^n-1, because 2^n is 1 in that channel
    // y_hi = (x_mid - x_hi) mod 2^n+1, because 2^n is -1 in that channel
    always_comb begin
        mid_red = (&x_mid) ? '0 : x_mid;
        d_lo    = {1'b0, x_lo} - {1'b0, mid_red};
        d_lo_w  = d_lo + MOD_LO;
        y_lo    = d_lo[N] ? d_lo_w[N-1:0] : d_lo[N-1:0];
        d_hi    = {2'b00, x_mid} - {1'b0, x_hi};
        d_hi_w  = d_hi + MOD_HI;
        y_hi    = d_hi[N+1] ? d_hi_w[N:0] : d_hi[N:0];
    end
endmodule

// File: rtl/rns_crt_rebuild.sv
module rns_crt_rebuild #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0]   y_lo,
    input  logic [N:0]     y_hi,
    output logic [2*N-1:0] y_bin
);
    localparam logic [N:0] MOD_LO = {1'b0, {N{1'b1}}};

    logic [N:0]   hi_red;
    logic [N:0]   d, d_w;
    logic [N-1:0] dd, k;

    // Y = y_hi + (2^n+1)*k, with k = (y_lo - y_hi)*inv(2) mod 2^n-1.
    // Halving modulo 2^n-1 is a right rotate.
    always_comb begin
        hi_red = (y_hi >= MOD_LO) ? (y_hi - MOD_LO) : y_hi;
        d      = {1'b0, y_lo} - {1'b0, hi_red[N-1:0]};
        d_w    = d + MOD_LO;
        dd     = d[N] ? d_w[N-1:0] : d[N-1:0];
        k      = {dd[0], dd[N-1:1]};
        y_bin  = {{(N-1){1'b0}}, y_hi}
               + {k, {N{1'b0}}}
               + {{N{1'b0}}, k};
    end
endmodule

// File: rtl/rns_sign_fix.sv
module rns_sign_fix
    import rns_scale_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input  logic [2*N-1:0] y_bin,
    input  logic           mid_msb,
    output logic [N-1:0]   r_mid
);
    sgn_e sgn;
    logic edge_case;

    // Upper half: Y >= 2^(2n-1), or Y = 2^(2n-1)-1 with the dropped
    // middle residue at least 2^(n-1).
    always_comb begin
        edge_case = ~y_bin[2*N-1] & (&y_bin[2*N-2:0]) & mid_msb;
        sgn       = (y_bin[2*N-1] | edge_case) ? SGN_NEG : SGN_NONNEG;
        // Subtracting 2^(2n)-1 is adding 1 modulo 2^n
        r_mid     = y_bin[N-1:0] + {{(N-1){1'b0}}, (sgn == SGN_NEG)};
    end
endmodule

// File: rtl/rns_signed_scaler.sv
module rns_signed_scaler
    import rns_scale_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] in_r_lo,
    input  logic [N-1:0] in_r_mid,
    input  logic [N:0]   in_r_hi,
    output logic         out_valid,
    output logic [N-1:0] out_r_lo,
    output logic [N-1:0] out_r_mid,
    output logic [N:0]   out_r_hi
);
    localparam int unsigned YW = 2 * N;

    typedef struct packed {
        logic         vld;
        logic [N-1:0] lo;
        logic [N:0]   hi;
        logic         mid_msb;
    } stage_t;

    logic [N-1:0]  d_lo;
    logic [N:0]    d_hi;
    stage_t        s1;
    logic [YW-1:0] y_bin;
    logic [N-1:0]  fixed_mid;

    rns_chan_diff #(.N(N)) u_diff (
        .x_lo  (in_r_lo),
        .x_mid (in_r_mid),
        .x_hi  (in_r_hi),
        .y_lo  (d_lo),
        .y_hi  (d_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= in_valid;
            if (in_valid) begin
                s1.lo      <= d_lo;
                s1.hi      <= d_hi;
                s1.mid_msb <= in_r_mid[N-1];
            end
        end
    end

    rns_crt_rebuild #(.N(N)) u_rebuild (
        .y_lo  (s1.lo),
        .y_hi  (s1.hi),
        .y_bin (y_bin)
    );

    rns_sign_fix #(.N(N)) u_fix (
        .y_bin   (y_bin),
        .mid_msb (s1.mid_msb),
        .r_mid   (fixed_mid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_r_lo  <= '0;
            out_r_mid <= '0;
            out_r_hi  <= '0;
        end else begin
            out_valid <= s1.vld;
            if (s1.vld) begin
                out_r_lo  <= s1.lo;
                out_r_mid <= fixed_mid;
                out_r_hi  <= s1.hi;
            end
        end
    end
endmodule

// File: rtl/rns_signed_scaler_chk.sv
module rns_signed_scaler_chk #(
    parameter int unsigned N = 6
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic [N-1:0] out_r_lo,
    input logic [N-1:0] out_r_mid,
    input logic [N:0]   out_r_hi
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_lat_high_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    p_lat_low_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && !out_valid) |-> ($stable(out_r_lo) && $stable(out_r_mid) && $stable(out_r_hi)));

    p_canon_lo_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_r_lo != {N{1'b1}}));

    p_canon_hi_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_r_hi <= {1'b1, {N{1'b0}}}));
endmodule

bind rns_signed_scaler rns_signed_scaler_chk #(.N(N)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_r_lo  (out_r_lo),
    .out_r_mid (out_r_mid),
    .out_r_hi  (out_r_hi)
);

// File: tb/test_rns_signed_scaler.sv
module test_rns_signed_scaler;
    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   errors = 0;

    always #5 clk = ~clk;

    logic       v3, v4, v8;
    logic [2:0] a3, b3;  logic [3:0] c3;
    logic [3:0] a4, b4;  logic [4:0] c4;
    logic [7:0] a8, b8;  logic [8:0] c8;
    logic       ov3, ov4, ov8;
    logic [2:0] o3a, o3b; logic [3:0] o3c;
    logic [3:0] o4a, o4b; logic [4:0] o4c;
    logic [7:0] o8a, o8b; logic [8:0] o8c;

    rns_signed_scaler #(.N(4)) i_rns_signed_scaler (
        .clk(clk), .rst(rst), .in_valid(v4), .in_r_lo(a4), .in_r_mid(b4), .in_r_hi(c4),
        .out_valid(ov4), .out_r_lo(o4a), .out_r_mid(o4b), .out_r_hi(o4c));
    rns_signed_scaler #(.N(3)) i_rns_signed_scaler_n3 (
        .clk(clk), .rst(rst), .in_valid(v3), .in_r_lo(a3), .in_r_mid(b3), .in_r_hi(c3),
        .out_valid(ov3), .out_r_lo(o3a), .out_r_mid(o3b), .out_r_hi(o3c));
    rns_signed_scaler #(.N(8)) i_rns_signed_scaler_n8 (
        .clk(clk), .rst(rst), .in_valid(v8), .in_r_lo(a8), .in_r_mid(b8), .in_r_hi(c8),
        .out_valid(ov8), .out_r_lo(o8a), .out_r_mid(o8b), .out_r_hi(o8c));

    task automatic check_val(string tag, int n, longint x, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s n=%0d X=%0d: got %0d expected %0d", tag, n, x, got, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Drive X (unsigned encoding) into the instance of width n and check the quotient
    task automatic run_x(int n, longint x, bit bnd);
        longint m1 = (longint'(1) << n) - 1;
        longint m2 = longint'(1) << n;
        longint m3 = (longint'(1) << n) + 1;
        longint mm = m1 * m2 * m3;
        longint xs, q, g1, g2, g3;
        @(negedge clk);
        case (n)
            3: begin v3 = 1'b1; a3 = 3'(x % m1); b3 = 3'(x % m2); c3 = 4'(x % m3); end
            4: begin v4 = 1'b1; a4 = 4'(x % m1); b4 = 4'(x % m2); c4 = 5'(x % m3); end
            default: begin v8 = 1'b1; a8 = 8'(x % m1); b8 = 8'(x % m2); c8 = 9'(x % m3); end
        endcase
        @(negedge clk);
        @(negedge clk);
        case (n)
            3: begin g1 = longint'(o3a); g2 = longint'(o3b); g3 = longint'(o3c); end
            4: begin g1 = longint'(o4a); g2 = longint'(o4b); g3 = longint'(o4c); end
            default: begin g1 = longint'(o8a); g2 = longint'(o8b); g3 = longint'(o8c); end
        endcase
        xs = (x >= mm / 2) ? x - mm : x;
        q  = xs >>> n;
        check_val(bnd ? "R4/R1" : "R1", n, x, g1, ((q % m1) + m1) % m1);
        check_val(bnd ? "R4/R2" : "R2", n, x, g2, ((q % m2) + m2) % m2);
        check_val(bnd ? "R4/R3" : "R3", n, x, g3, ((q % m3) + m3) % m3);
    endtask

    task automatic run_bounds(int n);
        longint mm = ((longint'(1) << n) - 1) * (longint'(1) << n) * ((longint'(1) << n) + 1);
        run_x(n, 0, 1'b1);
        run_x(n, mm / 2 - 1, 1'b1);
        run_x(n, mm / 2, 1'b1);
        run_x(n, mm / 2 + 1, 1'b1);
        run_x(n, mm - 1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: got no completion, expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] h_a, h_b; logic [4:0] h_c;
        v3 = 0; v4 = 0; v8 = 0;
        a3 = 0; b3 = 0; c3 = 0; a4 = 0; b4 = 0; c4 = 0; a8 = 0; b8 = 0; c8 = 0;
        repeat (3) @(negedge clk);
        // R5: reset state
        check_val("R5 valid", 4, 0, longint'(ov4), 0);
        check_val("R5 lo", 4, 0, longint'(o4a), 0);
        check_val("R5 mid", 4, 0, longint'(o4b), 0);
        check_val("R5 hi", 4, 0, longint'(o4c), 0);
        rst = 1'b0;
        @(negedge clk);

        // R6: a one-cycle pulse appears exactly two cycles later
        v4 = 1'b1; a4 = 4'd3; b4 = 4'd9; c4 = 5'd2;
        @(negedge clk);
        v4 = 1'b0;
        check_val("R6 after 1", 4, 0, longint'(ov4), 0);
        @(negedge clk);
        check_val("R6 after 2", 4, 0, longint'(ov4), 1);
        @(negedge clk);
        check_val("R6 after 3", 4, 0, longint'(ov4), 0);

        // R7: outputs hold while idle inputs change
        h_a = o4a; h_b = o4b; h_c = o4c;
        for (int i = 0; i < 4; i++) begin
            a4 = 4'(i + 5); b4 = 4'(i * 3); c4 = 5'(i + 11);
            @(negedge clk);
        end
        check_val("R7 lo", 4, 0, longint'(o4a), longint'(h_a));
        check_val("R7 mid", 4, 0, longint'(o4b), longint'(h_b));
        check_val("R7 hi", 4, 0, longint'(o4c), longint'(h_c));
        check_val("R7 valid", 4, 0, longint'(ov4), 0);

        // R4 boundaries for each width
        run_bounds(3);
        run_bounds(4);
        run_bounds(8);

        // R1 R2 R3 exhaustive for n = 3 and 4
        for (longint x = 0; x < 504; x++) run_x(3, x, 1'b0);
        for (longint x = 0; x < 4080; x++) run_x(4, x, 1'b0);
        // Spread sweep for n = 8
        for (longint i = 0; i < 2048; i++) run_x(8, i * 8191 + (i % 7), 1'b0);

        v3 = 0; v4 = 0; v8 = 0;
        repeat (3) @(negedge clk);
        check_val("R6 drain", 8, 0, longint'(ov8), 0);
        summary();
        $finish;
    end
endmodule